// File: doc/BRIEF.md
# Hardwired Micro-Operation Sequencer CPU

This block is a small accumulator processor whose control unit is hardwired. Every instruction is carried out as a numbered chain of register transfers over an address register, a data buffer register, a program counter, an instruction register and one accumulator. A 2-bit phase code picks which chain is running: instruction fetch, operand indirection, execution or interrupt entry. A 2-bit step counter numbers the transfers inside that chain. Both codes are visible at the ports.

The block drives a single-port word memory. It supplies the address, the write data and separate read and write strobes. The memory returns read data one clock edge after a read is requested. The instruction set holds four operations: add a memory word to the accumulator, increment a memory word and skip the next instruction if the result is zero, branch after storing the return address, and halt. A level-sensitive interrupt request is honoured between instructions. When it is taken, the return address is stored at a fixed save location and control jumps to a fixed service address.

Top module: `micro_seq_cpu`

## Requirements
- R1: After reset, pc and acc are 0, phase is 00 (fetch), step is 0, halted is 0 and interrupts are enabled.
- R2: An instruction word has the opcode in bits 15:13 (add=000, increment-skip=001, branch-save=010, halt=111), the indirect flag in bit 12 and the operand address in bits 11:0. The phase codes are 00 fetch, 01 indirect, 10 execute and 11 interrupt.
- R3: Fetch always lasts exactly three cycles. It reads the word at pc, and pc has been incremented by one when fetch ends.
- R4: If the indirect flag of the fetched word is set, the indirect phase lasts exactly three cycles. It replaces the operand address with bits 11:0 of the memory word at that address. If the flag is clear, the indirect phase is skipped.
- R5: Add sets acc to acc plus the word at the operand address, modulo 2^16.
- R6: Increment-skip stores the word at the operand address plus one, modulo 2^16, back to that address. If the stored value is zero, the following instruction is skipped.
- R7: Branch-save writes the address of the following instruction to the operand address and continues execution at the operand address plus one.
- R8: At the end of an execute phase, a high irq with interrupts enabled starts a three-cycle interrupt phase. That phase stores pc at SAVE_ADDR, sets pc to ISR_ADDR and disables interrupts, so later requests are ignored.
- R9: Halt sets halted. From then on pc and acc hold their values and no memory read or write is issued.
- R10: Read and write strobes are never high together, and a write occurs only in the execute or interrupt phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | 1 | Interrupt request, level |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 16 | Write data |
| mem_rd | output | 1 | Read request, sampled by memory at the clock edge |
| mem_wr | output | 1 | Write strobe, sampled by memory at the clock edge |
| phase | output | 2 | Current phase code |
| step | output | 2 | Timing step inside the phase |
| halted | output | 1 | Processor has executed halt |
| acc | output | 16 | Accumulator |
| pc | output | 12 | Program counter |

## Verification
On every cycle, the assertions check the following: the strobe exclusion and the phases in which writes may occur, the increment of pc in the second fetch step, interrupts staying disabled while the interrupt phase runs, the step bound for fetch, indirect and interrupt, and the freeze of pc and acc once halted. Only the bench's program runs can show the arithmetic results in memory and in acc. The same holds for the skip taken only on a zero result, the return address stored by branch-save and the saved pc at the interrupt location. The bench also counts the cycles spent in fetch, indirect and interrupt over whole programs, and that per-phase timing is likewise something only those runs can show.

// File: rtl/micro_seq_cpu.sv
module micro_seq_cpu #(
  parameter int DW        = 16,
  parameter int AW        = 12,
  parameter int SAVE_ADDR = 'h0F0,
  parameter int ISR_ADDR  = 'h0F1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq,
  input  logic [15:0]   mem_rdata,
  output logic [11:0]   mem_addr,
  output logic [15:0]   mem_wdata,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [1:0]    phase,
  output logic [1:0]    step,
  output logic          halted,
  output logic [15:0]   acc,
  output logic [11:0]   pc
);
  localparam int IND_BIT = DW - 4;
  localparam logic [1:0] PH_FETCH = 2'b00, PH_IND = 2'b01, PH_EXEC = 2'b10, PH_INT = 2'b11;
  localparam logic [2:0] OP_ADD = 3'b000, OP_ISZ = 3'b001, OP_BSA = 3'b010, OP_HALT = 3'b111;

  logic [AW-1:0] pc_q, pc_d, mar_q, mar_d;
  logic [DW-1:0] mbr_q, mbr_d, ir_q, ir_d, r1_q, r1_d;
  logic [1:0]    ph_q, ph_d, st_q, st_d;
  logic          ie_q, ie_d, halt_q, halt_d, rd, wr, done;

  wire [2:0]    opcode = ir_q[DW-1 -: 3];
  wire [AW-1:0] iraddr = ir_q[AW-1:0];

  always_comb begin
    pc_d = pc_q; mar_d = mar_q; mbr_d = mbr_q; ir_d = ir_q; r1_d = r1_q;
    ph_d = ph_q; st_d = st_q + 2'd1; ie_d = ie_q; halt_d = halt_q;
    rd = 1'b0; wr = 1'b0; done = 1'b0;
    if (halt_q) begin
      st_d = st_q;
    end else begin
      case (ph_q)
        PH_FETCH: case (st_q)
          2'd0: begin mar_d = pc_q; rd = 1'b1; end
          2'd1: begin mbr_d = mem_rdata; pc_d = pc_q + 1'b1; end
          default: begin
            ir_d = mbr_q; st_d = 2'd0;
            ph_d = mbr_q[IND_BIT] ? PH_IND : PH_EXEC;
          end
        endcase
        PH_IND: case (st_q)
          2'd0: begin mar_d = iraddr; rd = 1'b1; end
          2'd1: mbr_d = mem_rdata;
          default: begin
            ir_d = {ir_q[DW-1:AW], mbr_q[AW-1:0]};
            st_d = 2'd0; ph_d = PH_EXEC;
          end
        endcase
        PH_EXEC: case (opcode)
          OP_ADD: case (st_q)
            2'd0: begin mar_d = iraddr; rd = 1'b1; end
            2'd1: mbr_d = mem_rdata;
            default: begin r1_d = r1_q + mbr_q; done = 1'b1; end
          endcase
          OP_ISZ: case (st_q)
            2'd0: begin mar_d = iraddr; rd = 1'b1; end
            2'd1: mbr_d = mem_rdata;
            2'd2: mbr_d = mbr_q + 1'b1;
            default: begin
              wr = 1'b1;
              if (mbr_q == '0) pc_d = pc_q + 1'b1;
              done = 1'b1;
            end
          endcase
          OP_BSA: case (st_q)
            2'd0: begin mar_d = iraddr; mbr_d = DW'(pc_q); end
            2'd1: begin pc_d = iraddr; wr = 1'b1; end
            default: begin pc_d = pc_q + 1'b1; done = 1'b1; end
          endcase
          OP_HALT: begin halt_d = 1'b1; st_d = st_q; end
          default: done = 1'b1;
        endcase
        default: case (st_q)
          2'd0: mbr_d = DW'(pc_q);
          2'd1: begin mar_d = AW'(SAVE_ADDR); pc_d = AW'(ISR_ADDR); end
          default: begin wr = 1'b1; st_d = 2'd0; ph_d = PH_FETCH; end
        endcase
      endcase
      if (done) begin
        st_d = 2'd0;
        if (irq && ie_q) begin
          ph_d = PH_INT; ie_d = 1'b0;
        end else begin
          ph_d = PH_FETCH;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q <= '0; mar_q <= '0; mbr_q <= '0; ir_q <= '0; r1_q <= '0;
      ph_q <= PH_FETCH; st_q <= 2'd0; ie_q <= 1'b1; halt_q <= 1'b0;
    end else begin
      pc_q <= pc_d; mar_q <= mar_d; mbr_q <= mbr_d; ir_q <= ir_d; r1_q <= r1_d;
      ph_q <= ph_d; st_q <= st_d; ie_q <= ie_d; halt_q <= halt_d;
    end
  end

  assign mem_addr  = mar_d;
  assign mem_wdata = mbr_q;
  assign mem_rd    = rd;
  assign mem_wr    = wr;
  assign phase     = ph_q;
  assign step      = st_q;
  assign halted    = halt_q;
  assign acc       = r1_q;
  assign pc        = pc_q;

  a_r10_no_rd_wr: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  a_r10_wr_phase: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (phase == PH_EXEC || phase == PH_INT));
  a_r3_fetch_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_FETCH && st_q == 2'd1 && !halt_q) |=> pc_q == $past(pc_q) + 1'b1);
  a_r8_int_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_INT) |-> !ie_q);
  a_r4_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_EXEC) |-> st_q <= 2'd2);
  a_r9_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |=> (halt_q && $stable(pc_q) && $stable(r1_q)));
endmodule

// File: tb/micro_seq_cpu_tb_top.sv
module micro_seq_cpu_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, irq = 1'b0;
  logic [15:0] mem_rdata, mem_wdata, acc;
  logic [11:0] mem_addr, pc;
  logic mem_rd, mem_wr, halted;
  logic [1:0] phase, step;
  logic [15:0] mem [256];

  int checks = 0, fails = 0;
  int fetch_cyc, ind_cyc, int_cyc, bad_strobe, halt_access;

  always #(CLK_PERIOD/2) clk = ~clk;

  micro_seq_cpu dut_i (
    .clk(clk), .rst_n(rst_n), .irq(irq), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .phase(phase), .step(step), .halted(halted), .acc(acc), .pc(pc)
  );

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if ((mem_rd && mem_wr) || (mem_wr && !phase[1])) bad_strobe++;
      if (halted && (mem_rd || mem_wr)) halt_access++;
      if (!halted) begin
        if (phase == 2'b00) fetch_cyc++;
        if (phase == 2'b01) ind_cyc++;
        if (phase == 2'b11) int_cyc++;
      end
    end
  end

  function automatic logic [15:0] ins(input logic [2:0] op, input logic ind, input logic [11:0] a);
    return {op, ind, a};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
  endtask

  task automatic start();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    fetch_cyc = 0; ind_cyc = 0; int_cyc = 0; halt_access = 0;
    rst_n = 1'b1;
  endtask

  task automatic wait_halt(input string req);
    int n = 0;
    while (!halted && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (!halted) chk({req, " watchdog"}, 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] sum, v, r;
    logic [11:0] hpc;
    bad_strobe = 0;
    clear_mem();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 pc", pc, 0);
    chk("R1 acc", acc, 0);
    chk("R1/R2 phase fetch 00", phase, 0);
    chk("R1 step", step, 0);
    chk("R1 halted", halted, 0);

    // R5 and R4: sums over add chains, odd entries through an indirect pointer
    for (int k = 1; k <= 3; k++) begin
      clear_mem();
      sum = 16'h0;
      for (int i = 0; i < 8; i++) begin
        v = 16'(k * 16'h2345 + i * 16'h1111 + 16'h0F0F);
        mem[8'h40 + i] = v;
        sum = sum + v;
        if (i % 2 == 1) begin
          mem[i] = ins(3'b000, 1'b1, 12'(8'h80 + i));
          mem[8'h80 + i] = 16'hF000 | 16'(8'h40 + i);
        end else begin
          mem[i] = ins(3'b000, 1'b0, 12'(8'h40 + i));
        end
      end
      mem[8] = ins(3'b111, 1'b0, 12'h0);
      start();
      wait_halt("R5");
      chk("R5 acc sum", acc, sum);
      chk("R3 pc after halt", pc, 9);
      chk("R3 fetch cycles", fetch_cyc, 27);
      chk("R4 indirect cycles", ind_cyc, 12);
      hpc = pc;
      repeat (10) @(negedge clk);
      chk("R9 pc held", pc, hpc);
      chk("R9 acc held", acc, sum);
      chk("R9 no access", halt_access, 0);
    end

    // R6: increment-skip around wrap and zero
    for (int j = 0; j < 5; j++) begin
      clear_mem();
      case (j)
        0: v = 16'hFFFE;
        1: v = 16'hFFFF;
        2: v = 16'h0000;
        3: v = 16'h7FFF;
        default: v = 16'h1234;
      endcase
      r = v + 16'h1;
      mem[0] = ins(3'b001, 1'b0, 12'h040);
      mem[1] = ins(3'b000, 1'b0, 12'h041);
      mem[2] = ins(3'b000, 1'b0, 12'h042);
      mem[3] = ins(3'b111, 1'b0, 12'h0);
      mem[8'h40] = v; mem[8'h41] = 16'h1; mem[8'h42] = 16'h10;
      start();
      wait_halt("R6");
      chk("R6 stored value", mem[8'h40], r);
      chk("R6 skip acc", acc, (r == 16'h0) ? 16'h10 : 16'h11);
      chk("R6 fetch cycles", fetch_cyc, (r == 16'h0) ? 9 : 12);
      chk("R6 pc", pc, 4);
    end

    // R7: branch-save to several targets
    for (int j = 0; j < 4; j++) begin
      logic [11:0] x;
      clear_mem();
      x = 12'(8'h60 + j * 8'h18);
      mem[0] = ins(3'b000, 1'b0, 12'h041);
      mem[1] = ins(3'b010, 1'b0, x);
      mem[2] = ins(3'b111, 1'b0, 12'h0);
      mem[x[7:0] + 8'd1] = ins(3'b000, 1'b0, 12'h042);
      mem[x[7:0] + 8'd2] = ins(3'b111, 1'b0, 12'h0);
      mem[8'h41] = 16'h5; mem[8'h42] = 16'h3;
      start();
      wait_halt("R7");
      chk("R7 saved return", mem[x[7:0]], 2);
      chk("R7 acc", acc, 8);
      chk("R7 pc", pc, 32'(x) + 3);
    end

    // R8: request held high from reset, taken once only
    clear_mem();
    mem[0] = ins(3'b000, 1'b0, 12'h041);
    mem[1] = ins(3'b000, 1'b0, 12'h041);
    mem[2] = ins(3'b111, 1'b0, 12'h0);
    mem[8'hF1] = ins(3'b000, 1'b0, 12'h042);
    mem[8'hF2] = ins(3'b111, 1'b0, 12'h0);
    mem[8'h41] = 16'h0100; mem[8'h42] = 16'h0023;
    irq = 1'b1;
    start();
    wait_halt("R8");
    irq = 1'b0;
    chk("R8 saved pc", mem[8'hF0], 1);
    chk("R8 pc", pc, 12'h0F3);
    chk("R8 acc", acc, 16'h0123);
    chk("R8 interrupt cycles", int_cyc, 3);
    chk("R8 fetch cycles", fetch_cyc, 9);

    chk("R10 strobe rules", bad_strobe, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule